// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and turns them into one request line and a program address. Each of the eight sources has a pending flag. A one-cycle event pulse on that source's input sets the flag. The flag stays set until the source is serviced or software clears it. Each source has its own enable bit. A single global enable gates every source at once.

While the global enable is one and at least one enabled flag is pending, the controller raises its request and shows the vector address of the winning source. The source with the lowest index wins. Its vector sits lowest in the table, just above the reset vector. When the core pulses acknowledge, the controller clears the winning flag and the global enable in the same edge. A return strobe from the core sets the global enable again. Software can also set the global enable early inside a handler, so that any pending enabled source can preempt that handler.

Software reaches the block through one write port. A 2-bit select picks what the write does: load the enable mask, clear flags, write the global enable, or nothing.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is low, and after it is released, all pending flags, all enable bits and the global enable read zero, and the request output is low.
- R2: An event pulse on a source sets its pending flag on the next edge, whatever the state of that source's enable bit. The flag then stays set without any further pulse.
- R3: The request output is high exactly when the global enable is one and some source has both its flag and its enable bit set. Among such sources the lowest index wins.
- R4: While the request is high, the vector output equals base + (index + 1) × spacing. The reset vector sits at base. With the defaults (base 0, spacing 1), source i gives vector i + 1.
- R5: An acknowledge while the request is high clears the winning source's flag and the global enable on the same edge. An acknowledge while the request is low changes nothing.
- R6: A return strobe sets the global enable on the next edge. An acknowledge taken on the same edge wins over the strobe, and so does a global-enable write.
- R7: If software sets the global enable while flags stay pending (nesting), the request rises again with the vector of the highest-priority pending enabled source.
- R8: A write with select 1 clears every flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R9: An event that arrives on the same edge as a software clear or a hardware clear of its flag wins, and the flag stays set.
- R10: A write with select 0 loads the data into the enable mask. A write with select 2 loads data bit 0 into the global enable. A write with select 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | One-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 enables, 1 flag clear, 2 global enable, 3 none |
| wr_data_i | input | 8 | Write data |
| irq_ack_i | input | 1 | Core takes the presented vector |
| reti_i | input | 1 | Core executed a return from interrupt |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 12 | Vector address of the winning source |
| flags_o | output | 8 | Pending flags |
| enables_o | output | 8 | Enable mask |
| gie_o | output | 1 | Global enable |

## Verification
The bench targets the points where the flag, enable and global-enable updates collide on one edge. It checks an event against a write-one clear, an event against the acknowledge of its own source, and a return strobe against a taken acknowledge. A design that ordered these updates wrongly would drop a request or leave the global enable set on entry to a handler. The bench also sets a flag while its enable bit is zero, checks that it is kept and later serviced, and checks priority among several pending sources. A wrong priority shows up as the vector of a lower-priority source. An acknowledge with no request and a write with the unused select must leave all state alone. A design that did not guard them would clear a flag or the global enable out of turn.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    WR_ENABLE  = 2'd0,
    WR_FLAGCLR = 2'd1,
    WR_GIE     = 2'd2,
    WR_NONE    = 2'd3
  } wr_sel_e;

  // Vector address of source idx; slot 0 of the table belongs to reset.
  function automatic int vector_of(input int base, input int step, input int idx);
    return base + (idx + 1) * step;
  endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_sw_i,
  input  logic [N-1:0] clr_hw_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] kill_w;

  assign kill_w  = clr_sw_i | clr_hw_i;
  assign flags_o = flags_q;

  // a new event takes precedence over any clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~kill_w) | evt_i;
  end

  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_sw_i & ~evt_i)) |=> ((flags_o & $past(clr_sw_i & ~evt_i)) == '0));
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pending_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  logic [N:0] blocked_w;
  assign blocked_w[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign onehot_o[g]    = pending_i[g] & ~blocked_w[g];
    assign blocked_w[g+1] = blocked_w[g] | pending_i[g];
  end

  assign any_o = blocked_w[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
  end

  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(onehot_o) && (any_o == (pending_i != '0)));
endmodule

// File: rtl/irqc_gie_ctrl.sv
module irqc_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic wr_i,
  input  logic wr_val_i,
  input  logic reti_i,
  output logic gie_o
);
  logic gie_q;
  assign gie_o = gie_q;

  // precedence: vector taken, then software write, then return strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (take_i) gie_q <= 1'b0;
    else if (wr_i)   gie_q <= wr_val_i;
    else if (reti_i) gie_q <= 1'b1;
  end

  assert_entry_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !gie_o);

  assert_return_unmasks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_i && !wr_i) |=> gie_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC    = 8,
  parameter int ADDR_W   = 12,
  parameter int VEC_BASE = 0,
  parameter int VEC_STEP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  input  logic              irq_ack_i,
  input  logic              reti_i,
  output logic              irq_req_o,
  output logic [ADDR_W-1:0] irq_vec_o,
  output logic [N_SRC-1:0]  flags_o,
  output logic [N_SRC-1:0]  enables_o,
  output logic              gie_o
);
  import irqc_pkg::*;

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  wr_sel_e            sel_w;
  logic [N_SRC-1:0]   en_q;
  logic [N_SRC-1:0]   pending_w;
  logic [N_SRC-1:0]   win_onehot_w;
  logic [N_SRC-1:0]   clr_sw_w;
  logic [N_SRC-1:0]   clr_hw_w;
  logic [IDX_W-1:0]   win_idx_w;
  logic               any_w;
  logic               take_w;
  logic               wr_gie_w;

  assign sel_w     = wr_sel_e'(wr_sel_i);
  assign pending_w = flags_o & en_q;
  assign irq_req_o = gie_o & any_w;
  assign take_w    = irq_req_o & irq_ack_i;
  assign clr_hw_w  = take_w ? win_onehot_w : '0;
  assign clr_sw_w  = (wr_en_i && sel_w == WR_FLAGCLR) ? wr_data_i : '0;
  assign wr_gie_w  = wr_en_i && sel_w == WR_GIE;
  assign irq_vec_o = ADDR_W'(vector_of(VEC_BASE, VEC_STEP, int'(win_idx_w)));
  assign enables_o = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           en_q <= '0;
    else if (wr_en_i && sel_w == WR_ENABLE) en_q <= wr_data_i;
  end

  irqc_flag_bank #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .clr_sw_i(clr_sw_w), .clr_hw_i(clr_hw_w), .flags_o(flags_o)
  );

  irqc_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .pending_i(pending_w),
    .any_o(any_w), .idx_o(win_idx_w), .onehot_o(win_onehot_w)
  );

  irqc_gie_ctrl u_gie (
    .clk(clk), .rst_n(rst_n), .take_i(take_w), .wr_i(wr_gie_w),
    .wr_val_i(wr_data_i[0]), .reti_i(reti_i), .gie_o(gie_o)
  );

  assert_take_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && !evt_i[win_idx_w]) |=> !flags_o[$past(win_idx_w)]);

  assert_enable_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0) |=> (enables_o == $past(wr_data_i)));

  assert_req_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ((flags_o & enables_o) != '0) && gie_o);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic        req;
  logic [11:0] vec;
  logic [7:0]  flags, enables;
  logic        gie;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string phase = "R1";

  bit [7:0] m_flag, m_en;
  bit       m_gie;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .irq_ack_i(ack), .reti_i(reti), .irq_req_o(req),
    .irq_vec_o(vec), .flags_o(flags), .enables_o(enables), .gie_o(gie)
  );

  always #5 clk = ~clk;

  function automatic int winner();
    if (!m_gie) return -1;
    for (int i = 0; i < 8; i++)
      if (m_flag[i] && m_en[i]) return i;
    return -1;
  endfunction

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = '0; m_en = '0; m_gie = 1'b0;
    end else begin
      int w;
      bit took;
      bit [7:0] nf;
      w = winner();
      took = (w >= 0) && ack;
      nf = m_flag;
      if (took) nf[w] = 1'b0;
      if (wr_en && wr_sel == 2'd1) nf = nf & ~wr_data;
      m_flag = nf | evt;
      if (wr_en && wr_sel == 2'd0) m_en = wr_data;
      if (took) m_gie = 1'b0;
      else if (wr_en && wr_sel == 2'd2) m_gie = wr_data[0];
      else if (reti) m_gie = 1'b1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare against the model every cycle, away from the rising edge
  always @(negedge clk) begin
    int w;
    cycles++;
    w = winner();
    check({phase, " req"}, int'(req), int'(w >= 0));
    if (w >= 0) check({phase, " vec"}, int'(vec), w + 1);
    check({phase, " flags"}, int'(flags), int'(m_flag));
    check({phase, " enables"}, int'(enables), int'(m_en));
    check({phase, " gie"}, int'(gie), int'(m_gie));
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input logic [7:0] e, input logic a, input logic r,
                     input logic w, input logic [1:0] s, input logic [7:0] d);
    evt = e; ack = a; reti = r; wr_en = w; wr_sel = s; wr_data = d;
    @(negedge clk);
    evt = '0; ack = 1'b0; reti = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", int'(flags), 0);
    check("R1 gie in reset", int'(gie), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after reset", int'(req), 0);

    phase = "R2";
    cyc(8'h20, 0, 0, 0, 0, 0);
    check("R2 flag set while disabled", int'(flags), 8'h20);
    cyc(0, 0, 0, 0, 0, 0);
    check("R2 flag held", int'(flags), 8'h20);

    phase = "R10";
    cyc(0, 0, 0, 1, 2'd0, 8'hFF);
    check("R10 enable load", int'(enables), 8'hFF);
    check("R3 no req while gie low", int'(req), 0);
    cyc(0, 0, 0, 1, 2'd2, 8'h01);
    check("R10 gie write", int'(gie), 1);
    check("R4 vec of source 5", int'(vec), 6);

    phase = "R3";
    cyc(8'h04, 0, 0, 0, 0, 0);
    check("R3 lower index wins", int'(vec), 3);

    phase = "R5";
    cyc(0, 1, 0, 0, 0, 0);
    check("R5 taken flag cleared", int'(flags), 8'h20);
    check("R5 gie cleared on entry", int'(gie), 0);
    cyc(0, 1, 0, 0, 0, 0);
    check("R5 ack without req ignored", int'(flags), 8'h20);

    phase = "R7";
    cyc(8'h02, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 2'd2, 8'h01);
    check("R7 nested req", int'(req), 1);
    check("R7 nested vec", int'(vec), 2);

    phase = "R6";
    cyc(0, 1, 1, 0, 0, 0);
    check("R6 ack wins over return", int'(gie), 0);
    cyc(0, 0, 1, 0, 0, 0);
    check("R6 return sets gie", int'(gie), 1);

    phase = "R8";
    cyc(8'h81, 0, 0, 1, 2'd0, 8'h00);
    cyc(0, 0, 0, 1, 2'd1, 8'h20);
    check("R8 write-one clears", int'(flags), 8'h81);
    cyc(0, 0, 0, 1, 2'd1, 8'h00);
    check("R8 write-zero keeps", int'(flags), 8'h81);

    phase = "R9";
    cyc(8'h01, 0, 0, 1, 2'd1, 8'h01);
    check("R9 event beats sw clear", int'(flags[0]), 1);
    cyc(0, 0, 0, 1, 2'd0, 8'h01);
    cyc(8'h01, 1, 0, 0, 0, 0);
    check("R9 event beats hw clear", int'(flags[0]), 1);

    phase = "R10";
    cyc(0, 0, 0, 1, 2'd3, 8'hFF);
    check("R10 select 3 no effect", int'(enables), 8'h01);

    phase = "R3";
    for (int n = 0; n < 400; n++) begin
      logic [7:0] e;
      logic [1:0] s;
      e = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      s = 2'($urandom);
      cyc(e, 1'($urandom), ($urandom % 5 == 0), ($urandom % 4 == 0), s, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule